// File: doc/BRIEF.md
# Gated Clock Branch with Running Status

This block gates one downstream clock from a free-running source clock and tells software whether that downstream clock is really running. Three requests can turn the branch on, and any one of them is enough. The first is a software enable bit in the control word. The second is a vote bit in a separate vote word. The third is a hardware hold input that the interconnect drives when it needs the clock kept alive.

The combined request crosses into the source clock domain and drives a latch-based gate. That gate only changes state while the source clock is low, so the gated output never carries a clipped pulse. A running flag is set on the first gated rising edge. That flag crosses back into the register clock domain and drives a read-only off bit and a four-bit check code. Software polls these after changing a request.

The register port is a simple synchronous one, with a write strobe, a read strobe, a word address and a data word. Read data is combinational and valid in the same cycle as the read strobe.

Top module: `brgate_top`

## Requirements
- R1: Bit 0 of the control word (address 0) is the software enable. A write to address 0 stores wdata[0], and the value reads back from the next cycle on. Clearing it, while no other request is active, stops the gated clock and brings the off bit back to 1.
- R2: Bit 31 of the control word is read-only. It reads 1 while the gated clock is stopped. It reads 0 only after at least one gated rising edge has appeared, and it is still 1 in the cycle right after an enabling write.
- R3: The vote word at address 1 holds the vote bit at position VOTE_BIT (default 4). The vote bit alone starts the gated clock, and control bit 0 stays 0 while it does.
- R4: The gated output stays low while the branch is off. No high pulse of the gated output is shorter than the high phase of the source clock.
- R5: Bits 31:28 of the control word form a check code with three values. 4'b1000 means the clock is not running. 4'b0000 means it is running because of the enable bit or the vote bit. 4'b0010 means it is running and the hold input is the only active request.
- R6: After reset the control word reads 32'h8000_0000, the vote word reads 0, and the gated output is low.
- R7: Only control bit 0 and vote bit VOTE_BIT can be written. All other written bits are dropped and read back as 0, apart from the status bits of the control word. A read with rd_en low returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| src_clk | input | 1 | Free-running source clock to be gated |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (1) | Word address: 0 = control, 1 = vote |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, combinational |
| hold_req | input | 1 | Interconnect hold-on request, synchronous to clk |
| gclk | output | 1 | Gated branch clock |

## Verification
A register write is stored at the next clk edge, so the bench reads the stored bits back at the following falling edge. The status path runs through several registers: a request flop, two source-domain synchronizer stages, the gate latch, the running flop and two register-domain stages. Its latency is therefore several cycles and varies with the phase of the two clocks. For that reason the bench does not wait a fixed number of cycles. It polls the control word once per clk cycle, within a bounded window, and checks at once that the off bit is still set in the first cycle after an enabling write. While polling, it also checks that a gated rising edge had already been recorded when the off bit is first seen low. A separate monitor times every high pulse of the gated output against the source half-period.

// File: rtl/brgate_pkg.sv
package brgate_pkg;

  typedef enum logic [3:0] {
    CHK_ON     = 4'b0000,
    CHK_HELD   = 4'b0010,
    CHK_OFF    = 4'b1000
  } chk_code_e;

  // check code from the synchronized running flag and the request sources
  function automatic logic [3:0] calc_check(input logic running,
                                            input logic sw_or_vote,
                                            input logic hold);
    if (!running)                return CHK_OFF;
    else if (!sw_or_vote && hold) return CHK_HELD;
    else                         return CHK_ON;
  endfunction

endpackage

// File: rtl/brgate_sync.sv
module brgate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    genvar i;
    for (i = 0; i <= LAST; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[LAST];
endmodule

// File: rtl/brgate_icg.sv
module brgate_icg (
  input  logic src_clk,
  input  logic rst_n,
  input  logic en,
  output logic gate_open,
  output logic gated
);
  logic open_l;

  // transparent only while the source clock is low
  always_latch begin
    if (!src_clk) open_l = en;
  end

  assign gate_open = open_l;
  assign gated     = src_clk & open_l;

  // R4: latch output seen at a rising edge equals the enable held over the low phase
  assert_gate_follows_R4: assert property (@(posedge src_clk) disable iff (!rst_n)
    open_l == en);
endmodule

// File: rtl/brgate_regs.sv
module brgate_regs #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 1,
  parameter int VOTE_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              hold_req,
  input  logic              running,
  output logic              req
);
  import brgate_pkg::*;

  localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;
  localparam logic [ADDR_W-1:0] VOTE_ADDR = ADDR_W'(1);
  localparam int CHK_LSB = DATA_W - 4;

  logic sw_en, vote_en, req_q;
  logic [3:0] chk;
  logic [DATA_W-1:0] ctrl_word, vote_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_en   <= 1'b0;
      vote_en <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      if (wr_en && addr == CTRL_ADDR) sw_en   <= wdata[0];
      if (wr_en && addr == VOTE_ADDR) vote_en <= wdata[VOTE_BIT];
      req_q <= sw_en | vote_en | hold_req;
    end
  end

  assign req = req_q;
  assign chk = calc_check(running, sw_en | vote_en, hold_req);

  always_comb begin
    ctrl_word = '0;
    ctrl_word[DATA_W-1:CHK_LSB] = chk;
    ctrl_word[0] = sw_en;
    vote_word = '0;
    vote_word[VOTE_BIT] = vote_en;
    if (!rd_en)                 rdata = '0;
    else if (addr == CTRL_ADDR) rdata = ctrl_word;
    else if (addr == VOTE_ADDR) rdata = vote_word;
    else                        rdata = '0;
  end

  assert_ctrl_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == CTRL_ADDR) |=> sw_en == $past(wdata[0]));
  assert_vote_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == VOTE_ADDR) |=> vote_en == $past(wdata[VOTE_BIT]));
  assert_code_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chk == CHK_ON) || (chk == CHK_HELD) || (chk == CHK_OFF));
  assert_off_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[DATA_W-1] == !running);
endmodule

// File: rtl/brgate_top.sv
module brgate_top #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 1,
  parameter int VOTE_BIT = 4,
  parameter int SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              hold_req,
  output logic              gclk
);
  logic req, en_src, gate_open, running_src, running;

  brgate_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .VOTE_BIT(VOTE_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .hold_req(hold_req), .running(running), .req(req));

  brgate_sync #(.STAGES(SYNC_N)) u_req_sync (
    .clk(src_clk), .rst_n(rst_n), .d(req), .q(en_src));

  brgate_icg u_icg (
    .src_clk(src_clk), .rst_n(rst_n), .en(en_src), .gate_open(gate_open), .gated(gclk));

  // set on the first gated rising edge, cleared on the first suppressed one
  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) running_src <= 1'b0;
    else        running_src <= gate_open;
  end

  brgate_sync #(.STAGES(SYNC_N)) u_run_sync (
    .clk(clk), .rst_n(rst_n), .d(running_src), .q(running));

  // R2: running flag can only rise after a rising edge was passed through
  assert_run_after_edge_R2: assert property (@(posedge src_clk) disable iff (!rst_n)
    $rose(running_src) |-> $past(gate_open));
endmodule

// File: tb/tb_brgate_top.sv
module tb_brgate_top;
  logic clk = 0, src_clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, hold_req = 0;
  logic [0:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic gclk;
  int checks = 0, errors = 0;
  int gedges = 0, short_pulses = 0;
  realtime t_rise;

  always #5 clk = ~clk;
  always #7 src_clk = ~src_clk;

  brgate_top dut (.clk(clk), .rst_n(rst_n), .src_clk(src_clk), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .hold_req(hold_req), .gclk(gclk));

  always @(posedge gclk) begin gedges++; t_rise = $realtime; end
  always @(negedge gclk) if ($realtime - t_rise < 6.9) short_pulses++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; wdata = '0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a; #1 d = rdata; rd_en = 0;
  endtask

  // poll until the off bit equals want; check edge ordering on first "on"
  task automatic wait_off(input logic want, input string req, output logic [31:0] d);
    for (int i = 0; i < 60; i++) begin
      rd(0, d);
      if (d[31] == want) begin
        if (!want) chk({req, " edge before on"}, 32'(gedges > 0), 32'd1);
        return;
      end
    end
    chk({req, " timeout"}, {31'd0, d[31]}, {31'd0, want});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(0, d); chk("R6 ctrl", d, 32'h8000_0000);
    rd(1, d); chk("R6 vote", d, 32'h0);
    chk("R6 gclk", {31'd0, gclk}, 32'd0);
    repeat (10) @(negedge clk);
    chk("R4 no edge while off", 32'(gedges), 32'd0);
    @(negedge clk); chk("R7 no rd_en", rdata, 32'h0);
  endtask

  task automatic t_sw;
    logic [31:0] d;
    wr(0, 32'h1);
    rd(0, d); chk("R2 still off after write", d, 32'h8000_0001);
    wait_off(0, "R2", d);
    chk("R5 code on", d, 32'h0000_0001);
    repeat (20) @(negedge clk);
    chk("R4 edges running", 32'(gedges > 5), 32'd1);
    wr(0, 32'h0);
    wait_off(1, "R1", d);
    chk("R1 off word", d, 32'h8000_0000);
    repeat (4) @(negedge clk);
    gedges = 0; repeat (10) @(negedge clk);
    chk("R1 gclk stopped", 32'(gedges), 32'd0);
  endtask

  task automatic t_vote;
    logic [31:0] d;
    wr(1, 32'hFFFF_FFFF);
    rd(1, d); chk("R7 vote bits", d, 32'h0000_0010);
    wait_off(0, "R3", d);
    chk("R3 ctrl bit0 clear", d, 32'h0000_0000);
    wr(1, 32'h0);
    wait_off(1, "R3 off", d);
  endtask

  task automatic t_hold;
    logic [31:0] d;
    @(negedge clk); hold_req = 1;
    wait_off(0, "R5 hold", d);
    chk("R5 held code", d, 32'h2000_0000);
    wr(0, 32'h1);
    rd(0, d); chk("R5 sw+hold code", d, 32'h0000_0001);
    wr(0, 32'h0);
    @(negedge clk); hold_req = 0;
    wait_off(1, "R5 off", d);
    chk("R5 off code", d, 32'h8000_0000);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr(0, 32'hFFFF_FFFE);
    rd(0, d); chk("R7 ctrl mask", d, 32'h8000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk); rst_n = 1;
    t_reset; t_sw; t_vote; t_hold; t_mask;
    chk("R4 short pulses", 32'(short_pulses), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule